// File: doc/BRIEF.md
# Gated Auto-Reload Timer

This block is an 8-bit timer/counter with automatic reload. It counts one of two sources: a prescaled enable pulse from inside the chip, or rising edges on an external clock pin that it synchronizes to the system clock. An external gate pin can hold the count while the gate is low. The gate is used only when software enables it.

When the counter wraps past its all-ones value, four things happen. The counter takes the reload value again. A one-cycle overflow tick is issued. A toggle output changes state. A sticky overflow flag is set. The overflow tick has other users besides this block. A PWM unit uses it to set its period rate, and a serial shift unit uses it to build its shift clock. The toggle output runs at half the overflow rate.

Software reaches the block through a small word-addressed register bus. One register holds the reload value. One holds the control bits. One holds the status flag. The current count can be read back.

Top module: `gated_reload_timer`

## Requirements
- R1: After reset the count, reload, control and flag are all zero, the toggle output is 0, the overflow tick is 0 and the interrupt is 0.
- R2: A write to address 0 (reload) while the run bit is 0 also loads the counter at once. The count is read at address 3.
- R3: When run is set and the internal source is selected (control bit 1 = 0), the counter steps by one on every cycle in which `tick_in` is 1. From 0xFF it steps to the reload value, so overflows repeat every 256 − reload steps.
- R4: A write to the reload register while running leaves the counter unchanged. The new value is used from the next overflow onward.
- R5: With control bit 1 = 1, the counter steps once per rising edge of `ext_clk` and `tick_in` has no effect. `ext_clk` passes through two flops before edge detection, and each of its levels must last at least 4 clocks.
- R6: With the gate-enable bit (control bit 2) set, counting happens only while `gate` is 1. `gate` is synchronized through two flops.
- R7: `toggle_out` inverts on every overflow.
- R8: `ovf_tick` is high for exactly one cycle per overflow, registered at the clock edge where the counter wraps.
- R9: The overflow flag (status bit 0, address 2) stays set until a write of 1 to status bit 0. An overflow in the same cycle as that write wins.
- R10: `irq` is the overflow flag gated by the interrupt-enable bit (control bit 3).
- R11: With run (control bit 0) cleared, the counter holds its value and no overflow occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | Prescaled internal count enable |
| ext_clk | input | 1 | External count clock pin |
| gate | input | 1 | External gate pin |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 reload, 1 control, 2 status, 3 count |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| ovf_tick | output | 1 | One-cycle overflow pulse, used as a rate tick |
| toggle_out | output | 1 | Output that inverts on each overflow |
| irq | output | 1 | Interrupt request |

## Verification
If the counter state is wrong, the overflow tick and the toggle output show it within one reload period. They come too soon, too late, or not at all. The count readback shows it on the next read. If the source or gate selection is wrong, the counter moves while it should hold, or holds while it should move. A bad flag shows up on `irq` straight away. The bench counts overflow pulses and toggle edges over fixed windows and compares them with the period computed from the reload value. It also reads the count at points where its value is known.

// File: rtl/gated_reload_timer.sv
module gated_reload_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_in,
  input  logic         ext_clk,
  input  logic         gate,
  input  logic         reg_we,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic         ovf_tick,
  output logic         toggle_out,
  output logic         irq
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] count, reload;
  logic         run, ext_sel, gate_en, irq_en, flag;
  logic [2:0]   ext_sync;
  logic [1:0]   gate_sync;
  logic         ext_rise, src_step, gate_ok, step, wrap;
  logic         wr_reload, wr_ctrl, clr_flag;

  assign ext_rise  = ext_sync[1] & ~ext_sync[2];
  assign src_step  = ext_sel ? ext_rise : tick_in;
  assign gate_ok   = ~gate_en | gate_sync[1];
  assign step      = run & gate_ok & src_step;
  assign wrap      = step & (count == TOP);
  assign wr_reload = reg_we & (reg_addr == 2'd0);
  assign wr_ctrl   = reg_we & (reg_addr == 2'd1);
  assign clr_flag  = reg_we & (reg_addr == 2'd2) & reg_wdata[0];
  assign irq       = flag & irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_sync  <= '0;
      gate_sync <= '0;
    end else begin
      ext_sync  <= {ext_sync[1:0], ext_clk};
      gate_sync <= {gate_sync[0], gate};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      ext_sel <= 1'b0;
      gate_en <= 1'b0;
      irq_en  <= 1'b0;
      reload  <= '0;
    end else begin
      if (wr_ctrl) {irq_en, gate_en, ext_sel, run} <= reg_wdata[3:0];
      if (wr_reload) reload <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (wr_reload && !run) count <= reg_wdata;
    else if (wrap) count <= reload;
    else if (step) count <= count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_tick   <= 1'b0;
      toggle_out <= 1'b0;
      flag       <= 1'b0;
    end else begin
      ovf_tick <= wrap;
      if (wrap) toggle_out <= ~toggle_out;
      if (wrap) flag <= 1'b1;
      else if (clr_flag) flag <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = reload;
      2'd1:    reg_rdata = W'({irq_en, gate_en, ext_sel, run});
      2'd2:    reg_rdata = W'(flag);
      default: reg_rdata = count;
    endcase
  end
endmodule

module gated_reload_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         reg_we,
  input logic [1:0]   reg_addr,
  input logic [W-1:0] reg_wdata,
  input logic         ovf_tick,
  input logic         toggle_out,
  input logic         irq,
  input logic         run,
  input logic         ext_sel,
  input logic         flag,
  input logic [W-1:0] count
);
  a_r7_toggle_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_tick |-> (toggle_out != $past(toggle_out)));

  a_r7_toggle_only_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_tick |-> $stable(toggle_out));

  a_r11_stopped_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !ovf_tick);

  a_r11_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !reg_we) |=> $stable(count));

  a_r5_ext_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sel && $past(ext_sel) && ovf_tick) |=> !ovf_tick);

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(reg_we && reg_addr == 2'd2 && reg_wdata[0])) |=> flag);

  a_r10_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !reg_we) |=> irq);

  a_r8_flag_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_tick |-> flag);
endmodule

bind gated_reload_timer gated_reload_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .ovf_tick(ovf_tick), .toggle_out(toggle_out),
  .irq(irq), .run(run), .ext_sel(ext_sel), .flag(flag), .count(count)
);

// File: tb/test_gated_reload_timer.sv
module test_gated_reload_timer;
  logic       clk = 0, rst_n = 0, tick_in = 0, ext_clk = 0, gate = 0;
  logic       reg_we = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       ovf_tick, toggle_out, irq;
  int vectors = 0, errors = 0;

  always #5 clk = ~clk;

  gated_reload_timer i_gated_reload_timer (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .ext_clk(ext_clk),
    .gate(gate), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ovf_tick(ovf_tick), .toggle_out(toggle_out),
    .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic count_pulses(input int n, output int ticks, output int flips);
    logic last;
    ticks = 0; flips = 0;
    last = toggle_out;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ovf_tick) ticks++;
      if (toggle_out != last) flips++;
      last = toggle_out;
    end
  endtask

  task automatic t_reset;
    int v;
    rd(2'd3, v); check("R1 count", v, 0);
    rd(2'd0, v); check("R1 reload", v, 0);
    rd(2'd1, v); check("R1 control", v, 0);
    rd(2'd2, v); check("R1 flag", v, 0);
    check("R1 toggle", toggle_out, 0);
    check("R1 tick", ovf_tick, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_load_stopped;
    int v;
    wr(2'd0, 8'h5A);
    rd(2'd3, v); check("R2 stopped load", v, 'h5A);
  endtask

  task automatic t_internal;
    int t, f, v;
    tick_in = 1;
    wr(2'd0, 8'hFD);
    wr(2'd1, 8'b1001);
    repeat (5) @(negedge clk);
    count_pulses(30, t, f);
    check("R3 period 3", t, 10);
    check("R8 one pulse per overflow", t, 10);
    check("R7 toggles", f, 10);
    check("R10 irq raised", irq, 1);
    wr(2'd1, 8'b1000);
    rd(2'd2, v); check("R9 flag held", v, 1);
    repeat (4) @(negedge clk);
    rd(2'd2, v); check("R9 flag sticky", v, 1);
    wr(2'd1, 8'b0000);
    check("R10 irq masked", irq, 0);
    wr(2'd2, 8'h01);
    rd(2'd2, v); check("R9 flag cleared", v, 0);
    wr(2'd1, 8'b1000);
    check("R10 irq off after clear", irq, 0);
  endtask

  task automatic t_reload_running;
    int t, f, v;
    tick_in = 1;
    wr(2'd1, 8'b0000);
    wr(2'd0, 8'hFD);
    wr(2'd1, 8'b0001);
    repeat (5) @(negedge clk);
    wr(2'd0, 8'hF0);
    rd(2'd3, v); check("R4 counter kept", (v >= 'hFD) ? 1 : 0, 1);
    repeat (20) @(negedge clk);
    count_pulses(64, t, f);
    check("R4 new period 16", t, 4);
  endtask

  task automatic t_external;
    int t, f, x;
    wr(2'd1, 8'b0000);
    wr(2'd0, 8'hFE);
    tick_in = 1;
    wr(2'd1, 8'b0011);
    t = 0; f = 0;
    for (int p = 0; p < 10; p++) begin
      ext_clk = 1;
      count_pulses(4, x, f); t += x;
      ext_clk = 0;
      count_pulses(4, x, f); t += x;
    end
    count_pulses(6, x, f); t += x;
    check("R5 ext edges give 5 overflows", t, 5);
    count_pulses(20, t, f);
    check("R5 tick_in ignored", t, 0);
  endtask

  task automatic t_gate;
    int v, a, b;
    tick_in = 1; gate = 0;
    wr(2'd1, 8'b0000);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'b0101);
    repeat (20) @(negedge clk);
    rd(2'd3, v); check("R6 gate low holds", v, 0);
    gate = 1;
    repeat (12) @(negedge clk);
    rd(2'd3, v); check("R6 gate high counts", (v > 0) ? 1 : 0, 1);
    gate = 0;
    repeat (5) @(negedge clk);
    rd(2'd3, a);
    repeat (10) @(negedge clk);
    rd(2'd3, b); check("R6 gate closed again", b, a);
  endtask

  task automatic t_stop;
    int a, b, t, f;
    tick_in = 1;
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'b0000);
    rd(2'd3, a);
    count_pulses(20, t, f);
    rd(2'd3, b);
    check("R11 count held", b, a);
    check("R11 no overflow", t, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_load_stopped();
    t_internal();
    t_reload_running();
    t_external();
    t_gate();
    t_stop();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule